// File: doc/BRIEF.md
# Cycle Counter with Control Register

This block is a performance-monitor cycle counter reached through two registers on a simple synchronous register bus. One register holds a 32-bit running count of clock cycles. The other is a control word that starts and stops counting, clears the count, and picks a rate: every clock, or one step per 64 clocks.

Software reads either register at any time through a combinational read-data path. A write to the count register loads a new current value. A write to the control register updates only its writable bits. Bit 2 of the control write acts as a one-shot clear and is never stored. When the rate or the enable is changed, the count that has built up is kept. Only how the count advances from the next cycle on is different.

Top module: `cyc_counter`

## Requirements
- R1: While control bit 0 (run) is 1 and bit 3 is 0, the count rises by one on every clock edge, starting with the first edge after the control write that set bit 0.
- R2: While control bit 0 is 0, the count keeps its value.
- R3: While control bits 0 and 3 are both 1, the count rises once per 64 clock edges. A 6-bit prescaler supplies the step. The prescaler restarts from zero when bit 3 changes value through a control write, and when a control write sets bit 2.
- R4: A control write changes only bits 0, 3, 4 and 5 (mask 0x39), and all other written bits are ignored. A control read returns the stored bits, 0 in bits 1, 2 and 6 to 23, and the top byte of the IMPL_ID parameter in bits 31:24.
- R5: Control bit 5 is stored and read back, but it does not make the counter run or stop.
- R6: A count-register write loads the written value whether counting is enabled or not. When enabled, counting continues from that value on the next edge.
- R7: A control write that changes bit 0 or bit 3 keeps the accumulated count. The write edge itself still advances the count under the old settings, and the new settings apply from the following edge.
- R8: A control write that sets bits 2 and 0 together clears the count to zero on the write edge, and the count then keeps running from zero.
- R9: Reset puts the count at 0 and the control register at {IMPL_ID[31:24], 24'h0}. Reset asserts asynchronously and is released in step with the clock.
- R10: The count wraps from 0xFFFFFFFF to 0 with no flag.
- R11: Writing 1 to control bit 2 clears the count even when bit 0 is written as 0. Bit 2 always reads back as 0.
- R12: If a count-register write, a clear and an increment fall on the same edge, the written value wins. A clear wins over an increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| reg_sel | input | 1 | Register select: 0 control, 1 count |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the selected register |

## Verification
A write takes effect on the clock edge that samples the strobe. The read data shows the new value as soon as that edge has passed. In fast mode, each further edge adds one to the count. In slow mode, the step comes on the 64th edge after the prescaler restarts. The write edge itself still counts under the settings that held before the write, so expected values add that one step wherever the old settings were running. The bench drives and samples on the falling edge, after a known number of rising edges, and checks slow mode one edge before and exactly on the step.

// File: rtl/cyc_counter_pkg.sv
package cyc_counter_pkg;

  localparam int BUS_W = 32;

  typedef enum logic {
    SEL_CTRL  = 1'b0,
    SEL_COUNT = 1'b1
  } reg_sel_e;

  // control bit positions
  localparam int RUN_BIT  = 0;
  localparam int CLR_BIT  = 2;
  localparam int SLOW_BIT = 3;

  // bits software may change in the control word
  localparam logic [BUS_W-1:0] CTRL_WMASK = 32'h0000_0039;
  localparam logic [BUS_W-1:0] CTRL_IDMASK = 32'hFF00_0000;

endpackage

// File: rtl/cc_ctrl_reg.sv
module cc_ctrl_reg
  import cyc_counter_pkg::*;
#(
  parameter logic [BUS_W-1:0] IMPL_ID = 32'h5A00_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic [BUS_W-1:0] ctrl_o,
  output logic             run_o,
  output logic             slow_o,
  output logic             clr_o,
  output logic             slow_chg_o
);

  localparam logic [BUS_W-1:0] RST_VAL = IMPL_ID & CTRL_IDMASK;

  logic [BUS_W-1:0] ctrl_q;
  logic [BUS_W-1:0] ctrl_d;
  logic             ctrl_en;

  assign ctrl_en = wr_i;

  always_comb begin
    ctrl_d = (ctrl_q & ~CTRL_WMASK) | (wr_data_i & CTRL_WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= RST_VAL;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign run_o      = ctrl_q[RUN_BIT];
  assign slow_o     = ctrl_q[SLOW_BIT];
  assign clr_o      = wr_i & wr_data_i[CLR_BIT];
  assign slow_chg_o = wr_i & (wr_data_i[SLOW_BIT] != ctrl_q[SLOW_BIT]);

  // R4
  wmask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> ((ctrl_o & CTRL_WMASK) == ($past(wr_data_i) & CTRL_WMASK))
             && ((ctrl_o & ~CTRL_WMASK) == RST_VAL));

  // R4
  ctrl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(ctrl_o));

endmodule

// File: rtl/cc_prescale.sv
module cc_prescale #(
  parameter int DIV_LOG2 = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic restart_i,
  output logic tick_o
);

  logic [DIV_LOG2-1:0] pre_q;
  logic [DIV_LOG2-1:0] pre_d;
  logic                pre_en;

  assign pre_en = adv_i | restart_i;

  always_comb begin
    if (restart_i) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_en) begin
      pre_q <= pre_d;
    end
  end

  assign tick_o = adv_i & (&pre_q);

  // R3
  no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !tick_o);

endmodule

// File: rtl/cc_count_reg.sv
module cc_count_reg #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_data_i,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = ld_i | clr_i | inc_i;

  always_comb begin
    if (ld_i) begin
      cnt_d = ld_data_i;
    end else if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count_o = cnt_q;

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !clr_i && !inc_i) |=> $stable(count_o));

  // R12
  load_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (count_o == $past(ld_data_i)));

  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !ld_i) |=> (count_o == '0));

  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && !clr_i && (&count_o)) |=> (count_o == '0));

endmodule

// File: rtl/cyc_counter.sv
module cyc_counter
  import cyc_counter_pkg::*;
#(
  parameter logic [31:0] IMPL_ID  = 32'h5A00_0000,
  parameter int          CNT_W    = 32,
  parameter int          DIV_LOG2 = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data
);

  localparam int PAD_W = BUS_W - CNT_W;

  // asynchronous assert, clocked release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic             ctrl_wr;
  logic             cnt_wr;
  logic [BUS_W-1:0] ctrl_val;
  logic             run;
  logic             slow;
  logic             clr;
  logic             slow_chg;
  logic             pre_tick;
  logic             step;
  logic [CNT_W-1:0] cnt_val;

  assign ctrl_wr = wr_en & (reg_sel == SEL_CTRL);
  assign cnt_wr  = wr_en & (reg_sel == SEL_COUNT);

  cc_ctrl_reg #(
    .IMPL_ID (IMPL_ID)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_i       (ctrl_wr),
    .wr_data_i  (wr_data),
    .ctrl_o     (ctrl_val),
    .run_o      (run),
    .slow_o     (slow),
    .clr_o      (clr),
    .slow_chg_o (slow_chg)
  );

  cc_prescale #(
    .DIV_LOG2 (DIV_LOG2)
  ) pre_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .adv_i     (run & slow),
    .restart_i (clr | slow_chg),
    .tick_o    (pre_tick)
  );

  assign step = run & (slow ? pre_tick : 1'b1);

  cc_count_reg #(
    .CNT_W (CNT_W)
  ) cnt_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ld_i      (cnt_wr),
    .ld_data_i (wr_data[CNT_W-1:0]),
    .clr_i     (clr),
    .inc_i     (step),
    .count_o   (cnt_val)
  );

  // read mux
  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (reg_sel == SEL_COUNT) rd_data = {{PAD_W{1'b0}}, cnt_val};
        else                      rd_data = ctrl_val;
      end
    end else begin : g_nopad
      always_comb begin
        if (reg_sel == SEL_COUNT) rd_data = cnt_val;
        else                      rd_data = ctrl_val;
      end
    end
  endgenerate

  // R1
  fast_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (run && !slow && !wr_en) |=> (cnt_val == $past(cnt_val) + 1'b1));

  // R5
  dp_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!run && !wr_en) |=> $stable(cnt_val));

endmodule

// File: tb/cyc_counter_tb_top.sv
module cyc_counter_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] ID         = 32'h5A12_3456;
  localparam logic [31:0] ID_TOP     = 32'h5A00_0000;
  localparam int          NVEC       = 17;

  logic        clk;
  logic        rst_n;
  logic        reg_sel;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;

  int tests_run;
  int tests_failed;
  bit done;

  cyc_counter #(.IMPL_ID(ID), .CNT_W(32), .DIV_LOG2(6)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // write flag, select, data, idle edges, read select, expected, requirement
  typedef struct packed {
    logic        wr;
    logic        sel;
    logic [31:0] data;
    logic [7:0]  idle;
    logic        rsel;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 32'h0000_0001, 8'd10, 1'b1, 32'd10,          8'd1},  // R1 run fast
    '{1'b1, 1'b0, 32'h0000_0000, 8'd5,  1'b1, 32'd11,          8'd2},  // R2 hold
    '{1'b1, 1'b1, 32'h0000_0100, 8'd3,  1'b1, 32'h100,         8'd6},  // R6 load idle
    '{1'b1, 1'b0, 32'h0000_0001, 8'd4,  1'b1, 32'h104,         8'd6},  // R6 resume
    '{1'b1, 1'b1, 32'h0000_5000, 8'd2,  1'b1, 32'h5002,        8'd12}, // R12 load over step
    '{1'b1, 1'b0, 32'h0000_0009, 8'd63, 1'b1, 32'h5003,        8'd7},  // R7 to slow
    '{1'b0, 1'b0, 32'h0,         8'd1,  1'b1, 32'h5004,        8'd3},  // R3 64th edge
    '{1'b0, 1'b0, 32'h0,         8'd64, 1'b1, 32'h5005,        8'd3},  // R3 next step
    '{1'b1, 1'b0, 32'h0000_0001, 8'd5,  1'b1, 32'h500A,        8'd7},  // R7 back to fast
    '{1'b1, 1'b0, 32'h0000_0005, 8'd7,  1'b1, 32'd7,           8'd8},  // R8 clear+run
    '{1'b1, 1'b0, 32'h0000_0004, 8'd5,  1'b1, 32'd0,           8'd11}, // R11 clear only
    '{1'b1, 1'b0, 32'hFFFF_FFFF, 8'd1,  1'b0, 32'h5A00_0039,   8'd4},  // R4 mask
    '{1'b1, 1'b0, 32'h0000_0020, 8'd10, 1'b1, 32'd0,           8'd5},  // R5 bit5 alone
    '{1'b0, 1'b0, 32'h0,         8'd1,  1'b0, 32'h5A00_0020,   8'd5},  // R5 readback
    '{1'b1, 1'b0, 32'h0000_0021, 8'd6,  1'b1, 32'd6,           8'd5},  // R5 with run
    '{1'b1, 1'b1, 32'hFFFF_FFFE, 8'd1,  1'b1, 32'hFFFF_FFFF,   8'd10}, // R10 near top
    '{1'b0, 1'b0, 32'h0,         8'd1,  1'b1, 32'd0,           8'd10}  // R10 wrap
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [31:0] data);
    reg_sel = sel;
    wr_data = data;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 32'h0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests_failed++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tests_run = 0;
    tests_failed = 0;
    done = 1'b0;
    rst_n = 1'b0;
    reg_sel = 1'b0;
    wr_en = 1'b0;
    wr_data = 32'h0;

    // R9 reset values
    repeat (3) @(negedge clk);
    reg_sel = 1'b0;
    #1 check(rd_data, ID_TOP, 9);
    reg_sel = 1'b1;
    #1 check(rd_data, 32'h0, 9);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].sel, VECS[i].data);
      repeat (int'(VECS[i].idle)) @(negedge clk);
      reg_sel = VECS[i].rsel;
      #1 check(rd_data, VECS[i].exp, int'(VECS[i].req));
    end

    // R11 clear bit reads back as 0 after being written with run
    bus_write(1'b0, 32'h0000_0005);
    reg_sel = 1'b0;
    #1 check(rd_data, 32'h5A00_0001, 11);

    // R1 counting resumes one per edge after clear+run
    repeat (3) @(negedge clk);
    reg_sel = 1'b1;
    #1 check(rd_data, 32'd3, 1);

    // R9 reset asserted mid-run
    rst_n = 1'b0;
    #1 check(rd_data, 32'h0, 9);
    reg_sel = 1'b0;
    #1 check(rd_data, ID_TOP, 9);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reg_sel = 1'b1;
    #1 check(rd_data, 32'h0, 9);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule